// File: doc/BRIEF.md
# Serial ADC Host Interface Controller

This block drives one conversion at a time on a two-channel, 12-bit sampling converter that has a serial interface. When the block is idle and a start request arrives, it latches a two-bit input configuration, a bit-order choice and a clock divider setting. It then pulls the active-low chip select down and runs a fixed frame of serial clock cycles. In the first two cycles it sends the configuration bits. A parameterised number of idle cycles follows. The last twelve cycles carry the result bits back from the converter.

The received bits are put into a parallel word in their correct positions, whichever bit order was chosen. At the end of the frame, chip select returns high so the converter can shut itself down. A one-cycle done pulse then marks the result as valid. The serial clock rests low. Each serial cycle is a low half followed by a high half, and each half lasts `div_half+1` system clocks. The controller changes its serial output at the start of the low half. It samples the input at the rising edge.

Top module: `sadc_host_ctrl`

## Requirements
- R1: After reset, cs_n=1, sclk=0, mosi=0, busy=0, done=0 and result=0.
- R2: A start seen with busy=0 makes cs_n=0 and busy=1 from the next clock. The transaction then occupies exactly 2*(2+GAP_CYC+12)*(div_half+1) clocks with busy=1.
- R3: sclk is 0 whenever cs_n=1. Within a transaction, each serial cycle is div_half+1 clocks with sclk=0 followed by div_half+1 clocks with sclk=1.
- R4: mosi carries cfg_single in serial cycle 0 and cfg_odd in serial cycle 1. cfg_single=1 selects single-ended input, and cfg_single=0 selects differential input. cfg_odd picks the channel or the polarity. In every other cycle, and while idle, mosi is 0. mosi never changes while sclk is high.
- R5: In the GAP_CYC serial cycles after the configuration bits, the bits seen on miso are ignored. Result bits are sampled at the rising sclk edges of serial cycles 2+GAP_CYC through 13+GAP_CYC.
- R6: With lsb_first=0, the first result bit received is placed in result[11] and the last in result[0].
- R7: With lsb_first=1, the first result bit received is placed in result[0] and the last in result[11].
- R8: When the final half-cycle ends, cs_n returns to 1 and busy to 0 on the next clock. done is 1 for exactly that one clock, and result presents the new code in that clock. result then holds until the next done.
- R9: A start that arrives while busy=1 has no effect on the transaction in progress, on its timing, or on its result.
- R10: cfg_single, cfg_odd, lsb_first and div_half are captured when the start is accepted. Changes to them during a transaction have no effect.
- R11: The result is the straight-binary code exactly as received. For example, the codes 0x000, 0x800 and 0xFFF are delivered unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion |
| cfg_single | input | 1 | 1 = single-ended input, 0 = differential |
| cfg_odd | input | 1 | Channel select (single-ended) or polarity (differential) |
| lsb_first | input | 1 | 1 = result arrives least significant bit first |
| div_half | input | DIV_W | System clocks per sclk half-period, minus one |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse: result valid |
| result | output | DATA_W | Parallel conversion code |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to converter |
| mosi | output | 1 | Configuration bits to converter |
| miso | input | 1 | Result bits from converter |

## Verification
The end of one transaction and the acceptance of the next can fall in the same clock. In that clock done is high and busy is low, so a start held high is taken at once. The bench provokes this by holding start high across a complete frame.

It then judges three things against its cycle model. cs_n must rise for exactly the done clock. The second frame must start with fresh configuration bits and a fresh bit count. The first result must not be disturbed by the new frame.

A start pulse with different settings in the middle of a frame also checks that no acceptance happens while busy.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef struct packed {
    logic odd;
    logic single;
  } sadc_cfg_t;

  function automatic int frame_cycles(int cfg_w, int gap_w, int data_w);
    return cfg_w + gap_w + data_w;
  endfunction
endpackage

// File: rtl/sadc_clkdiv.sv
module sadc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             half_end
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  assign half_end = run && (cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      div_q <= div_half;
      cnt   <= '0;
    end else if (run) begin
      cnt <= half_end ? '0 : cnt + 1'b1;
    end
  end

  property p_half_bound;
    @(posedge clk) disable iff (!rst_n) run |-> (cnt <= div_q);
  endproperty
  assert_half_bound_R3: assert property (p_half_bound);

  property p_div_hold;
    @(posedge clk) disable iff (!rst_n) (run && !load) |=> $stable(div_q);
  endproperty
  assert_div_hold_R10: assert property (p_div_hold);
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq #(
  parameter int FRAME = 16,
  localparam int HALVES = 2 * FRAME,
  localparam int HW = $clog2(HALVES),
  localparam int BW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          half_end,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic          rise_evt,
  output logic          last_evt,
  output logic          sclk_hi,
  output logic [BW-1:0] bit_idx
);
  logic [HW-1:0] half_idx;

  assign accept   = start && !busy;
  assign rise_evt = half_end && !half_idx[0];
  assign last_evt = half_end && (half_idx == HW'(HALVES - 1));
  assign sclk_hi  = busy && half_idx[0];
  assign bit_idx  = half_idx[HW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      half_idx <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        half_idx <= '0;
      end else if (last_evt) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        half_idx <= '0;
      end else if (half_end) begin
        half_idx <= half_idx + 1'b1;
      end
    end
  end

  property p_accept;
    @(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy;
  endproperty
  assert_accept_R2: assert property (p_accept);

  property p_busy_cause;
    @(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy;
  endproperty
  assert_busy_cause_R9: assert property (p_busy_cause);

  property p_done_pulse;
    @(posedge clk) disable iff (!rst_n) done |=> !done;
  endproperty
  assert_done_pulse_R8: assert property (p_done_pulse);

  property p_done_idle;
    @(posedge clk) disable iff (!rst_n) done |-> !busy;
  endproperty
  assert_done_idle_R8: assert property (p_done_idle);

  property p_idx_frozen;
    @(posedge clk) disable iff (!rst_n) (busy && !half_end) |=> $stable(half_idx);
  endproperty
  assert_idx_frozen_R3: assert property (p_idx_frozen);
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift
  import sadc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CFG_W = 2,
  parameter int GAP_CYC = 2,
  localparam int FRAME = frame_cycles(CFG_W, GAP_CYC, DATA_W),
  localparam int BW = $clog2(FRAME),
  localparam int IW = $clog2(DATA_W),
  localparam int FIRST = CFG_W + GAP_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              busy,
  input  logic              rise_evt,
  input  logic              last_evt,
  input  logic [BW-1:0]     bit_idx,
  input  logic              cfg_single,
  input  logic              cfg_odd,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] result
);
  sadc_cfg_t         cfg_q;
  logic              lsb_q;
  logic [DATA_W-1:0] data_q;
  logic              in_data;
  logic [BW-1:0]     rel;
  logic [IW-1:0]     slot;

  function automatic logic [IW-1:0] place(logic [IW-1:0] j, logic lsb);
    return lsb ? j : (IW'(DATA_W - 1) - j);
  endfunction

  assign in_data = bit_idx >= BW'(FIRST);
  assign rel     = bit_idx - BW'(FIRST);
  assign slot    = place(rel[IW-1:0], lsb_q);

  always_comb begin
    mosi = 1'b0;
    if (busy && bit_idx == BW'(0)) mosi = cfg_q.single;
    else if (busy && bit_idx == BW'(1)) mosi = cfg_q.odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lsb_q  <= 1'b0;
      data_q <= '0;
      result <= '0;
    end else begin
      if (accept) begin
        cfg_q.single <= cfg_single;
        cfg_q.odd    <= cfg_odd;
        lsb_q        <= lsb_first;
        data_q       <= '0;
      end else if (rise_evt && in_data) begin
        data_q[slot] <= miso;
      end
      if (last_evt) result <= data_q;
    end
  end

  property p_cfg_hold;
    @(posedge clk) disable iff (!rst_n) busy |=> ($stable(cfg_q) && $stable(lsb_q));
  endproperty
  assert_cfg_hold_R10: assert property (p_cfg_hold);

  property p_result_hold;
    @(posedge clk) disable iff (!rst_n) !last_evt |=> $stable(result);
  endproperty
  assert_result_hold_R8: assert property (p_result_hold);

  property p_mosi_idle;
    @(posedge clk) disable iff (!rst_n) !busy |-> !mosi;
  endproperty
  assert_mosi_idle_R4: assert property (p_mosi_idle);
endmodule

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int GAP_CYC = 2,
  parameter int DIV_W = 8,
  localparam int CFG_W = 2,
  localparam int FRAME = frame_cycles(CFG_W, GAP_CYC, DATA_W),
  localparam int BW = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_single,
  input  logic              cfg_odd,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  div_half,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic          half_end;
  logic          accept;
  logic          rise_evt;
  logic          last_evt;
  logic          sclk_hi;
  logic [BW-1:0] bit_idx;

  sadc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
    .div_half(div_half), .half_end(half_end)
  );

  sadc_seq #(.FRAME(FRAME)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .half_end(half_end),
    .busy(busy), .done(done), .accept(accept), .rise_evt(rise_evt),
    .last_evt(last_evt), .sclk_hi(sclk_hi), .bit_idx(bit_idx)
  );

  sadc_shift #(.DATA_W(DATA_W), .CFG_W(CFG_W), .GAP_CYC(GAP_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
    .rise_evt(rise_evt), .last_evt(last_evt), .bit_idx(bit_idx),
    .cfg_single(cfg_single), .cfg_odd(cfg_odd), .lsb_first(lsb_first),
    .miso(miso), .mosi(mosi), .result(result)
  );

  assign cs_n = !busy;
  assign sclk = sclk_hi;

  property p_mosi_steady;
    @(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi);
  endproperty
  assert_mosi_steady_R4: assert property (p_mosi_steady);

  property p_sample_high;
    @(posedge clk) disable iff (!rst_n) rise_evt |=> sclk;
  endproperty
  assert_sample_high_R5: assert property (p_sample_high);
endmodule

// File: tb/sadc_host_ctrl_bench.sv
module sadc_host_ctrl_bench;
  localparam int DATA_W = 12;
  localparam int GAP_CYC = 2;
  localparam int DIV_W = 8;
  localparam int FRAME = 2 + GAP_CYC + DATA_W;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, cfg_single = 0, cfg_odd = 0, lsb_first = 0;
  logic [DIV_W-1:0] div_half = 0;
  logic busy, done, cs_n, sclk, mosi;
  logic miso = 0;
  logic [DATA_W-1:0] result;

  always #2 clk = ~clk;

  sadc_host_ctrl #(.DATA_W(DATA_W), .GAP_CYC(GAP_CYC), .DIV_W(DIV_W)) u_sadc_host_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_single(cfg_single),
    .cfg_odd(cfg_odd), .lsb_first(lsb_first), .div_half(div_half),
    .busy(busy), .done(done), .result(result), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // converter model
  int adc_value = 0;
  int rc = 0;
  int rx_cfg[2];
  int cur_value = 0;
  int cur_lsb = 0;

  function automatic logic data_bit(int c);
    int j;
    j = c - 2 - GAP_CYC;
    if (j < 0 || j >= DATA_W) return 1'b1;
    return cur_lsb != 0 ? 1'(cur_value >> j) : 1'(cur_value >> (DATA_W - 1 - j));
  endfunction

  always @(negedge cs_n) begin
    rc = 0;
    cur_value = adc_value;
    cur_lsb = int'(lsb_first);
    miso = data_bit(0);
  end

  always @(posedge sclk) begin
    if (rc < 2) rx_cfg[rc] = int'(mosi);
    rc++;
    miso = data_bit(rc);
  end

  // cycle reference model
  int rb = 0, rd = 0, cnt = 0, hcap = 1, rs = 0, ro = 0, rres = 0, rval = 0;
  int q_cfg[$];

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      rb = 0; rd = 0; cnt = 0; rres = 0;
    end else begin
      rd = 0;
      if (rb != 0) begin
        if (cnt == 2 * FRAME * hcap - 1) begin
          rb = 0; rd = 1; rres = rval;
        end else cnt++;
      end else if (start) begin
        rb = 1; cnt = 0; hcap = int'(div_half) + 1;
        rs = int'(cfg_single); ro = int'(cfg_odd); rval = adc_value;
        q_cfg.push_back(rs * 2 + ro);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int h, b, em;
      h = cnt / hcap;
      b = h / 2;
      em = (rb == 0) ? 0 : (b == 0) ? rs : (b == 1) ? ro : 0;
      chk("R2 busy", int'(busy), rb);
      chk("R2 cs_n", int'(cs_n), rb == 0 ? 1 : 0);
      chk("R3 sclk", int'(sclk), rb == 0 ? 0 : h % 2);
      chk("R4 mosi", int'(mosi), em);
      chk("R8 done", int'(done), rd);
      chk("R8 result", int'(result), rres);
      if (done) begin
        int e;
        e = q_cfg.pop_front();
        chk("R4 rx_cfg", rx_cfg[0] * 2 + rx_cfg[1], e);
        chk("R11 code", int'(result), rval);
      end
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic conv(bit s, bit o, bit lsb, int dv, int val, bit disturb);
    @(negedge clk);
    cfg_single = s; cfg_odd = o; lsb_first = lsb; div_half = DIV_W'(dv);
    adc_value = val; start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      // R9/R10: new settings and a start while busy must not matter
      repeat (7) @(negedge clk);
      cfg_single = ~s; cfg_odd = ~o; lsb_first = ~lsb; div_half = DIV_W'(dv + 2);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 mosi", int'(mosi), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 result", int'(result), 0);
    rst_n = 1;
    conv(1, 0, 0, 0, 'h000, 0);        // R6 R11 zero code
    conv(1, 1, 0, 1, 'h800, 0);        // R6 mid-scale
    conv(0, 0, 1, 2, 'hFFF, 0);        // R7 full scale
    conv(0, 1, 1, 0, 'hA5C, 0);        // R7 R5 gap bits driven 1
    conv(1, 0, 1, 3, 'h001, 1);        // R7 R9 R10
    conv(0, 1, 0, 1, 'h3C7, 1);        // R6 R9 R10
    // R8 R2 back to back: start held across done
    @(negedge clk);
    cfg_single = 1; cfg_odd = 1; lsb_first = 0; div_half = 1;
    adc_value = 'h5A3; start = 1;
    wait_done();
    adc_value = 'h1E6;
    wait_done();
    start = 0;
    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule